// File: doc/BRIEF.md
# PHY Control Register Bank with Per-Bit Write Enables

This block holds the static control settings of a storage-card PHY and presents them to the PHY as decoded fields. Software reaches it through a plain single-cycle bus: a request strobe, a write flag, a byte address and a 32-bit write word, with read data returned one clock later. Seven control words are available, and each one keeps 16 stored bits.

Every write word carries its own mask in its upper half. Bit x+16 of the written word allows stored bit x to take the value of write bit x. Stored bits whose mask bit is clear keep their value. Because of this, software can change one field, such as the DLL enable, without first reading the register back. A read-only status word returns the PHY's calibration-done and DLL-ready signals, sampled live.

The decoded outputs come straight from the stored bits. They are the power-down-bar control, the DLL enable and frequency select, the drive-strength code, the output tap-delay enable and select, and the strobe-line pull-down enable.

Top module: `phy_ctl_bank`

## Requirements
- R1: After reset every control word reads 0, except the word at offset 0x00, which reads 0x0200 (tap-delay select field = 4). The outputs show otap_sel = 4 and every other field 0.
- R2: A write to a control offset sets stored bit x (x in 0..15) to write bit x when write bit x+16 is 1. Stored bits whose mask bit is 0 keep their value.
- R3: A read of a control offset returns the stored 16 bits in rdata[15:0] and zeros in rdata[31:16]. The data is valid in the cycle after the request.
- R4: A read of offset 0x20 returns cal_done_i in bit 6 and dll_ready_i in bit 5, both sampled on the request's clock edge. All other bits are 0.
- R5: A write to 0x20, or to any offset that is not mapped, changes no stored bit. Mapped control offsets are 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18; any offset not a multiple of 4 is unmapped.
- R6: A read of an unmapped offset returns 0.
- R7: The word at 0x18 drives three fields: pwr_on_o from bit 0, dll_en_o from bit 1, and drive_sel_o from bits 6:4. The drive codes are 0 = 50 ohm, 1 = 33 ohm, 2 = 66 ohm, 3 = 100 ohm, 4 = 40 ohm.
- R8: The word at 0x00 drives dll_freq_o from bits 13:12, otap_en_o from bit 11 and otap_sel_o from bits 10:7.
- R9: The word at 0x08 drives strobe_pd_o from bit 9.
- R10: After a write, the decoded outputs show the new value in the cycle after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset |
| wdata_i | input | 32 | Write word: mask in [31:16], data in [15:0] |
| rdata_o | output | 32 | Read data, valid the cycle after the read request |
| cal_done_i | input | 1 | Calibration-done status from the PHY |
| dll_ready_i | input | 1 | DLL-ready status from the PHY |
| pwr_on_o | output | 1 | Power-down-bar control |
| dll_en_o | output | 1 | DLL enable |
| drive_sel_o | output | 3 | Drive-strength code |
| dll_freq_o | output | 2 | DLL frequency select |
| otap_en_o | output | 1 | Output tap-delay enable |
| otap_sel_o | output | 4 | Output tap-delay select |
| strobe_pd_o | output | 1 | Strobe-line pull-down enable |

## Verification
A write updates its word on the clock edge where it is presented, so the decoded outputs are checked at the falling edge that follows. Read data has one register stage, so it is due at the falling edge after the request edge. A monitor notes each read request at the rising edge, waits half a cycle, and compares rdata against the next entry in the scoreboard queue. Status inputs are changed at a falling edge ahead of the read, so the value sampled at the request edge is the value the bench expects.

// File: rtl/phy_ctl_bank.sv
module phy_ctl_bank #(
  parameter int ADDR_W   = 6,
  parameter int NUM_CTRL = 7,
  parameter int HALF_W   = 16,
  parameter logic [HALF_W-1:0] WORD0_RST = 16'h0200,
  parameter int STATUS_OFF = 'h20,
  parameter int CAL_BIT  = 6,
  parameter int DLL_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              cal_done_i,
  input  logic              dll_ready_i,
  output logic              pwr_on_o,
  output logic              dll_en_o,
  output logic [2:0]        drive_sel_o,
  output logic [1:0]        dll_freq_o,
  output logic              otap_en_o,
  output logic [3:0]        otap_sel_o,
  output logic              strobe_pd_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [HALF_W-1:0] word_q [NUM_CTRL];
  logic [IDX_W-1:0]  idx;
  logic              aligned, ctl_hit, stat_hit;
  logic [HALF_W-1:0] mask, rd_word;
  logic [31:0]       rd_next;

  assign idx      = addr_i[ADDR_W-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign ctl_hit  = aligned && (int'(idx) < NUM_CTRL);
  assign stat_hit = (int'(addr_i) == STATUS_OFF);
  assign mask     = wdata_i[2*HALF_W-1:HALF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CTRL; i++)
        word_q[i] <= (i == 0) ? WORD0_RST : '0;
    end else if (req_i && we_i && ctl_hit) begin
      for (int i = 0; i < NUM_CTRL; i++)
        if (idx == IDX_W'(i))
          word_q[i] <= (word_q[i] & ~mask) | (wdata_i[HALF_W-1:0] & mask);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (idx == IDX_W'(i)) rd_word = word_q[i];
    rd_next = '0;
    if (ctl_hit) begin
      rd_next[HALF_W-1:0] = rd_word;
    end else if (stat_hit) begin
      rd_next[CAL_BIT] = cal_done_i;
      rd_next[DLL_BIT] = dll_ready_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rdata_o <= '0;
    else if (req_i && !we_i)    rdata_o <= rd_next;
  end

  assign pwr_on_o    = word_q[6][0];
  assign dll_en_o    = word_q[6][1];
  assign drive_sel_o = word_q[6][6:4];
  assign dll_freq_o  = word_q[0][13:12];
  assign otap_en_o   = word_q[0][11];
  assign otap_sel_o  = word_q[0][10:7];
  assign strobe_pd_o = word_q[2][9];

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[31:HALF_W] == '0);

  a_r2_masked_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && int'(addr_i) == 'h18 && !wdata_i[HALF_W+1])
    |=> dll_en_o == $past(dll_en_o));

  a_r2_masked_bit_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && addr_i == '0 && wdata_i[HALF_W+11])
    |=> otap_en_o == $past(wdata_i[11]));

  a_r5_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && stat_hit)
    |=> $stable({pwr_on_o, dll_en_o, drive_sel_o, dll_freq_o, otap_en_o, otap_sel_o, strobe_pd_o}));

  a_r4_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && stat_hit)
    |=> rdata_o == ((32'($past(cal_done_i)) << CAL_BIT) | (32'($past(dll_ready_i)) << DLL_BIT)));

  a_r6_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && !ctl_hit && !stat_hit) |=> rdata_o == '0);
endmodule

// File: tb/tb_phy_ctl_bank.sv
module tb_phy_ctl_bank;
  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic cal = 0, dllr = 0;
  logic pwr, dlle, otpe, stpd;
  logic [2:0] drv;
  logic [1:0] frq;
  logic [3:0] otps;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string req; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  phy_ctl_bank dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cal_done_i(cal), .dll_ready_i(dllr),
    .pwr_on_o(pwr), .dll_en_o(dlle), .drive_sel_o(drv), .dll_freq_o(frq),
    .otap_en_o(otpe), .otap_sel_o(otps), .strobe_pd_o(stpd)
  );

  task automatic check(logic [31:0] act, logic [31:0] exp, string r);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] e, string r);
    item_t it;
    it.exp = e; it.req = r;
    sb.push_back(it);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
  endtask

  function automatic logic [31:0] outs();
    return 32'({pwr, dlle, drv, frq, otpe, otps, stpd});
  endfunction

  function automatic logic [31:0] mk(logic p, logic d, logic [2:0] dr, logic [1:0] f,
                                     logic oe, logic [3:0] os, logic sp);
    return 32'({p, d, dr, f, oe, os, sp});
  endfunction

  always @(posedge clk) begin
    if (req && !we) begin
      item_t it;
      @(negedge clk);
      it = sb.pop_front();
      check(rdata, it.exp, it.req);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(outs(), mk(0,0,3'd0,2'd0,0,4'd4,0), "R1 outputs");
    rd(6'h00, 32'h0000_0200, "R1 word0");
    for (int i = 1; i < 7; i++) rd(6'(i*4), 32'h0, "R1 wordN");
    // R2/R7/R10: power on, dll on, drive 40 ohm
    wr(6'h18, 32'h0073_0043);
    check(outs(), mk(1,1,3'd4,2'd0,0,4'd4,0), "R7 R10 fields 0x18");
    rd(6'h18, 32'h0000_0043, "R3 readback 0x18");
    // R2: only bit 1 enabled, other data bits ignored
    wr(6'h18, 32'h0002_FFFC);
    check(outs(), mk(1,0,3'd4,2'd0,0,4'd4,0), "R2 partial mask");
    rd(6'h18, 32'h0000_0041, "R2 readback");
    // R8
    wr(6'h00, 32'h3F80_2F80);
    check(outs(), mk(1,0,3'd4,2'd2,1,4'd15,0), "R8 fields 0x00");
    rd(6'h00, 32'h0000_2F80, "R8 readback");
    // R9
    wr(6'h08, 32'h0200_0200);
    check(outs(), mk(1,0,3'd4,2'd2,1,4'd15,1), "R9 strobe pulldown");
    rd(6'h08, 32'h0000_0200, "R9 readback");
    // R2 zero mask: no change
    wr(6'h08, 32'h0000_0000);
    rd(6'h08, 32'h0000_0200, "R2 zero mask");
    // R3 other words
    wr(6'h04, 32'hFFFF_1234);
    wr(6'h14, 32'hFFFF_ABCD);
    rd(6'h04, 32'h0000_1234, "R3 word1");
    rd(6'h14, 32'h0000_ABCD, "R3 word5");
    // R4 status
    cal = 1; dllr = 0;
    rd(6'h20, 32'h0000_0040, "R4 cal only");
    cal = 0; dllr = 1;
    rd(6'h20, 32'h0000_0020, "R4 dll only");
    cal = 1;
    rd(6'h20, 32'h0000_0060, "R4 both");
    // R5 ignored writes
    wr(6'h20, 32'hFFFF_FFFF);
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h01, 32'hFFFF_0000);
    wr(6'h3C, 32'hFFFF_0000);
    check(outs(), mk(1,0,3'd4,2'd2,1,4'd15,1), "R5 outputs unchanged");
    rd(6'h18, 32'h0000_0041, "R5 word6 unchanged");
    rd(6'h00, 32'h0000_2F80, "R5 word0 unchanged");
    rd(6'h20, 32'h0000_0060, "R5 status still live");
    // R6 unmapped reads
    rd(6'h1C, 32'h0, "R6 0x1C");
    rd(6'h24, 32'h0, "R6 0x24");
    rd(6'h01, 32'h0, "R6 misaligned");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule